// File: doc/BRIEF.md
# Receive byte clock generator

This block derives the receive-side byte clocks and their capture strobes from a bit-rate timebase. A bit counter divides the timebase into words of `WORD_BITS` bit times, so the word-rate clock runs at one tenth of the serial bit rate by default. Two mode pins set the output shape. With both low, the block drives a complementary pair of half-word-rate clocks, and each clock of the pair captures every other word. Otherwise a single word-rate clock appears on output 0 and output 1 is held low. The interface-mode pin has priority, so the clock-mode pin does not matter while it is high. In the double-data-rate interface mode, receive data is aligned to both edges of clock 0. A falling-edge strobe marks the second data phase.

The word aligner can ask for a new word boundary with a one-cycle request that carries a bit offset. The generator then holds its bit counter for that many bit times. Every output keeps its present level during the hold, so realignment only ever lengthens a pulse. Mode pins are sampled only at word boundaries, so a change in mode cannot cut a pulse short either.

Top module: `rx_byteclk_gen`

## Requirements
- R1: With `iface_ddr`=0 and `clk_mode`=0 (half-rate), `bclk0` and `bclk1` are always complementary. Each is high for `WORD_BITS` (10) bit times and low for 10, which gives a period of 20.
- R2: In half-rate mode, `bclk1` rises at the start of even words and `bclk0` rises at the start of odd words. Word 0 is the first word after reset release, so `bclk1` rises on the first clock edge after reset and `bclk0` rises 10 edges later. `cap1_stb` and `cap0_stb` are high for exactly the first cycle in which their clock is high.
- R3: With `iface_ddr`=0 and `clk_mode`=1, `bclk0` has a period of 10 bit times, high for 5 and low for 5. `bclk1` stays low.
- R4: With `iface_ddr`=1, `clk_mode` has no effect. `bclk0` behaves as in R3 and `bclk1` stays low.
- R5: `fall_stb` is high for exactly the first cycle in which `bclk0` is low after being high, and only while `iface_ddr`=1. In the other modes it stays 0.
- R6: A `realign_req` pulse with offset s in `realign_shift` holds the bit count for s bit times. All outputs keep their levels during the hold, so the next `bclk0` rise comes s bit times later. Offsets above `WORD_BITS`-1 are treated as 9, and s=0 has no effect.
- R7: A `realign_req` that arrives while an earlier hold is still running is ignored.
- R8: Mode pins take effect only at a word boundary. No pulse on either clock is ever shorter than 5 bit times, including across mode changes and realignment.
- R9: While `rst_n`=0 (a synchronous reset), all five outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate timebase |
| rst_n | input | 1 | Synchronous active-low reset |
| iface_ddr | input | 1 | 1 = 5-bit double-data-rate interface; has priority |
| clk_mode | input | 1 | 1 = single word-rate clock, 0 = half-rate pair |
| realign_req | input | 1 | One-cycle request from the aligner to shift the word boundary |
| realign_shift | input | $clog2(WORD_BITS) | Bit times to hold the count for |
| bclk0 | output | 1 | Byte clock 0 (odd words, or the word-rate clock) |
| bclk1 | output | 1 | Byte clock 1 (even words, or held low) |
| cap0_stb | output | 1 | First high cycle of bclk0 |
| cap1_stb | output | 1 | First high cycle of bclk1 |
| fall_stb | output | 1 | First low cycle of bclk0, in DDR mode only |

## Verification
On every cycle, the assertions check the following:
- the clock pair is complementary in half-rate mode;
- clock 1 is quiet in the word-rate modes;
- the falling strobe appears only in DDR mode;
- the bit count stays frozen while a hold is running;
- word parity and mode change only at a word boundary.

Pulse periods, the assignment of clock 1 to even words, and the minimum pulse width across realignment and mode switches depend on history over many cycles. Only the bench's scenarios show those, by measuring run lengths and rise-to-rise intervals at the ports.

// File: rtl/rx_byteclk_pkg.sv
// Shared types for the receive byte clock generator.
package rx_byteclk_pkg;

    // Output shape selected by the mode pins.
    typedef enum logic [1:0] {
        BCK_HALF = 2'd0,   // complementary pair, half word rate
        BCK_FULL = 2'd1,   // single word-rate clock
        BCK_DDR  = 2'd2    // single word-rate clock, both edges carry data
    } bck_mode_e;

    // Interface-mode pin wins; the clock-mode pin only matters when it is low.
    function automatic bck_mode_e bck_decode(input logic ddr, input logic full);
        if (ddr)
            return BCK_DDR;
        else if (full)
            return BCK_FULL;
        else
            return BCK_HALF;
    endfunction

endpackage

// File: rtl/rx_byteclk_timer.sv
// Bit timer: counts bit times 0..WORD_BITS-1 per word and keeps a word parity.
// A realign request freezes the count for a number of bit times instead of
// skipping ahead, so downstream levels only stretch. A request that arrives
// while a hold is running is dropped. Assumes a one-cycle request pulse.
module rx_byteclk_timer #(
    parameter int WORD_BITS = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         realign_req,
    input  logic [$clog2(WORD_BITS)-1:0] realign_shift,
    output logic [$clog2(WORD_BITS)-1:0] cnt,
    output logic                         word_par,
    output logic                         wrap
);
    localparam int CW   = $clog2(WORD_BITS);
    localparam int LAST = WORD_BITS - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] hold_q;
    logic [CW-1:0] hold_n;
    logic [CW-1:0] shift_c;
    logic          par_q;
    logic          freeze;

    // Clamp the offset and accept a new hold only when idle.
    always_comb begin
        shift_c = (realign_shift > CW'(LAST)) ? CW'(LAST) : realign_shift;
        hold_n  = (realign_req && hold_q == '0) ? shift_c : hold_q;
        freeze  = (hold_n != '0);
        wrap    = !freeze && (cnt_q == CW'(LAST));
    end

    // Advance or hold the bit count, track word parity and the remaining hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
            par_q  <= 1'b0;
        end else begin
            hold_q <= freeze ? hold_n - 1'b1 : '0;
            if (!freeze)
                cnt_q <= (cnt_q == CW'(LAST)) ? '0 : cnt_q + 1'b1;
            if (wrap)
                par_q <= ~par_q;
        end
    end

    assign cnt      = cnt_q;
    assign word_par = par_q;

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LAST));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q != '0) |=> $stable(cnt_q));

    // R8
    par_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(par_q) |-> ($past(cnt_q) == CW'(LAST)));

endmodule

// File: rtl/rx_byteclk_mode.sv
// Mode latch: samples the two mode pins at word boundaries only, so a pin
// change never reshapes a word already in progress. Loads directly in reset.
module rx_byteclk_mode
    import rx_byteclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      iface_ddr,
    input  logic      clk_mode,
    input  logic      wrap,
    output bck_mode_e mode
);
    bck_mode_e mode_q;

    // Capture the decoded pins at reset and at each word wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || wrap)
            mode_q <= bck_decode(iface_ddr, clk_mode);
    end

    assign mode = mode_q;

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mode_q));

endmodule

// File: rtl/rx_byteclk_shaper.sv
// Clock shaper: turns bit count, word parity and mode into registered byte
// clocks and one-cycle strobes. Assumes count and parity only change in a
// way that lengthens levels (held during realignment).
module rx_byteclk_shaper
    import rx_byteclk_pkg::*;
#(
    parameter int WORD_BITS = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(WORD_BITS)-1:0] cnt,
    input  logic                         word_par,
    input  bck_mode_e                    mode,
    output logic                         bclk0,
    output logic                         bclk1,
    output logic                         cap0_stb,
    output logic                         cap1_stb,
    output logic                         fall_stb
);
    localparam int CW       = $clog2(WORD_BITS);
    localparam int HALF_CNT = WORD_BITS / 2;

    logic b0_n;
    logic b1_n;
    logic b0_q;
    logic b1_q;

    // Next clock levels for the active mode.
    always_comb begin
        if (mode == BCK_HALF) begin
            b0_n = word_par;
            b1_n = ~word_par;
        end else begin
            b0_n = (cnt < CW'(HALF_CNT));
            b1_n = 1'b0;
        end
    end

    // Register clocks and derive edge strobes from old and new levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b0_q     <= 1'b0;
            b1_q     <= 1'b0;
            cap0_stb <= 1'b0;
            cap1_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            b0_q     <= b0_n;
            b1_q     <= b1_n;
            cap0_stb <= b0_n & ~b0_q;
            cap1_stb <= b1_n & ~b1_q;
            fall_stb <= (mode == BCK_DDR) & b0_q & ~b0_n;
        end
    end

    assign bclk0 = b0_q;
    assign bclk1 = b1_q;

    // R1
    half_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BCK_HALF) |=> (bclk0 != bclk1));

    // R3
    full_b1_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != BCK_HALF) |=> !bclk1);

    // R5
    fall_ddr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != BCK_DDR) |=> !fall_stb);

    // R2
    cap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap0_stb, cap1_stb}));

    // R2
    cap_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap0_stb |-> bclk0) and (cap1_stb |-> bclk1));

endmodule

// File: rtl/rx_byteclk_gen.sv
// Receive byte clock generator top: bit timer, mode latch and clock shaper.
// Assumes clk is the bit-rate timebase and realign_req is a single-cycle
// pulse from the word aligner.
module rx_byteclk_gen
    import rx_byteclk_pkg::*;
#(
    parameter int WORD_BITS = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         iface_ddr,
    input  logic                         clk_mode,
    input  logic                         realign_req,
    input  logic [$clog2(WORD_BITS)-1:0] realign_shift,
    output logic                         bclk0,
    output logic                         bclk1,
    output logic                         cap0_stb,
    output logic                         cap1_stb,
    output logic                         fall_stb
);
    localparam int CW = $clog2(WORD_BITS);

    logic [CW-1:0] cnt;
    logic          word_par;
    logic          wrap;
    bck_mode_e     mode;

    rx_byteclk_timer #(.WORD_BITS(WORD_BITS)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .realign_req   (realign_req),
        .realign_shift (realign_shift),
        .cnt           (cnt),
        .word_par      (word_par),
        .wrap          (wrap)
    );

    rx_byteclk_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .iface_ddr (iface_ddr),
        .clk_mode  (clk_mode),
        .wrap      (wrap),
        .mode      (mode)
    );

    rx_byteclk_shaper #(.WORD_BITS(WORD_BITS)) u_shaper (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .word_par (word_par),
        .mode     (mode),
        .bclk0    (bclk0),
        .bclk1    (bclk1),
        .cap0_stb (cap0_stb),
        .cap1_stb (cap1_stb),
        .fall_stb (fall_stb)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(bclk0 | bclk1 | cap0_stb | cap1_stb | fall_stb));

endmodule

// File: tb/rx_byteclk_gen_test.sv
// Directed bench for the receive byte clock generator.
module rx_byteclk_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iface_ddr = 1'b0;
    logic       clk_mode = 1'b0;
    logic       realign_req = 1'b0;
    logic [3:0] realign_shift = 4'd0;
    logic       bclk0, bclk1, cap0_stb, cap1_stb, fall_stb;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // Results of the last observation window.
    int r0, r1, f0, fc, hi1, same, stb_err;
    int min0h, min0l, min1h, min1l;

    rx_byteclk_gen #(.WORD_BITS(10)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .iface_ddr     (iface_ddr),
        .clk_mode      (clk_mode),
        .realign_req   (realign_req),
        .realign_shift (realign_shift),
        .bclk0         (bclk0),
        .bclk1         (bclk1),
        .cap0_stb      (cap0_stb),
        .cap1_stb      (cap1_stb),
        .fall_stb      (fall_stb)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watch n cycles; gather run lengths, edges and strobe consistency.
    task automatic observe(input int n, input bit ddr_exp);
        logic p0, p1;
        int   run0, run1;
        bit   seen0, seen1;
        r0 = 0; r1 = 0; f0 = 0; fc = 0; hi1 = 0; same = 0; stb_err = 0;
        min0h = 1000; min0l = 1000; min1h = 1000; min1l = 1000;
        run0 = 0; run1 = 0; seen0 = 0; seen1 = 0;
        @(negedge clk);
        p0 = bclk0; p1 = bclk1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bclk0 != p0) begin
                if (seen0) begin
                    if (p0) min0h = (run0 < min0h) ? run0 : min0h;
                    else    min0l = (run0 < min0l) ? run0 : min0l;
                end
                seen0 = 1; run0 = 1;
                if (bclk0) r0++; else f0++;
            end else run0++;
            if (bclk1 != p1) begin
                if (seen1) begin
                    if (p1) min1h = (run1 < min1h) ? run1 : min1h;
                    else    min1l = (run1 < min1l) ? run1 : min1l;
                end
                seen1 = 1; run1 = 1;
                if (bclk1) r1++;
            end else run1++;
            if (cap0_stb != (bclk0 & ~p0)) stb_err++;
            if (cap1_stb != (bclk1 & ~p1)) stb_err++;
            if (fall_stb != (ddr_exp & p0 & ~bclk0)) stb_err++;
            if (fall_stb) fc++;
            if (bclk1) hi1++;
            if (bclk0 == bclk1) same++;
            p0 = bclk0; p1 = bclk1;
        end
    endtask

    // Rise-to-rise interval of bclk0 with a realign request (optionally twice).
    task automatic realign_period(input int s, input bit twice, output int cycles);
        logic p;
        bit   found;
        p = bclk0;
        found = 0;
        while (!found) begin
            @(negedge clk);
            found = !p && bclk0;
            p = bclk0;
        end
        cycles = 0;
        found = 0;
        while (!found) begin
            @(negedge clk);
            cycles++;
            found = !p && bclk0;
            p = bclk0;
            if (cycles == 1) begin realign_req = 1'b1; realign_shift = 4'(s); end
            else if (cycles == 2) realign_req = twice;
            else realign_req = 1'b0;
        end
        realign_req = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        wait_cycles(3);
        chk({bclk0, bclk1, cap0_stb, cap1_stb, fall_stb} == 5'b0, "R9",
            "outputs in reset", {bclk0, bclk1, cap0_stb, cap1_stb, fall_stb}, 0);
    endtask

    task automatic t_first_word;
        iface_ddr = 1'b0; clk_mode = 1'b0;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        chk(bclk1 && cap1_stb && !bclk0, "R2", "word0 on bclk1 {b1,cap1,b0}",
            {bclk1, cap1_stb, bclk0}, 3'b110);
        wait_cycles(10);
        chk(bclk0 && cap0_stb && !bclk1, "R2", "word1 on bclk0 {b0,cap0,b1}",
            {bclk0, cap0_stb, bclk1}, 3'b110);
    endtask

    task automatic t_half;
        observe(200, 1'b0);
        chk(same == 0, "R1", "pair not complementary count", same, 0);
        chk(r0 == 10 && r1 == 10, "R1", "rises of bclk0 in 200", r0, 10);
        chk(min0h == 10 && min0l == 10 && min1h == 10 && min1l == 10, "R1",
            "half-rate min run", min0h, 10);
        chk(stb_err == 0, "R2", "capture strobe mismatches", stb_err, 0);
    endtask

    task automatic t_full;
        clk_mode = 1'b1;
        wait_cycles(25);
        observe(200, 1'b0);
        chk(r0 == 20, "R3", "bclk0 rises in 200", r0, 20);
        chk(min0h == 5 && min0l == 5, "R3", "bclk0 high run", min0h, 5);
        chk(hi1 == 0, "R3", "bclk1 high cycles", hi1, 0);
        chk(fc == 0 && stb_err == 0, "R5", "fall strobes outside DDR", fc, 0);
    endtask

    task automatic t_ddr;
        iface_ddr = 1'b1; clk_mode = 1'b0;
        wait_cycles(25);
        observe(100, 1'b1);
        chk(r0 == 10 && min0h == 5 && min0l == 5, "R4", "ddr clk_mode=0 rises", r0, 10);
        chk(hi1 == 0, "R4", "ddr clk_mode=0 bclk1 high", hi1, 0);
        chk(fc == 10 && stb_err == 0, "R5", "ddr fall strobes", fc, 10);
        clk_mode = 1'b1;
        wait_cycles(25);
        observe(100, 1'b1);
        chk(r0 == 10 && min0h == 5 && min0l == 5 && hi1 == 0, "R4",
            "ddr clk_mode=1 rises", r0, 10);
        chk(fc == 10 && stb_err == 0, "R5", "ddr fall strobes clk_mode=1", fc, 10);
        iface_ddr = 1'b0;
        wait_cycles(25);
    endtask

    task automatic t_realign;
        int p;
        realign_period(3, 1'b0, p);
        chk(p == 13, "R6", "period with shift 3", p, 13);
        realign_period(0, 1'b0, p);
        chk(p == 10, "R6", "period with shift 0", p, 10);
        realign_period(12, 1'b0, p);
        chk(p == 19, "R6", "period with shift 12 clamped", p, 19);
        realign_period(5, 1'b1, p);
        chk(p == 15, "R7", "second request during hold", p, 15);
    endtask

    task automatic t_boundary;
        logic p;
        bit   found;
        int   hi0, b1hi;
        clk_mode = 1'b1; iface_ddr = 1'b0;
        wait_cycles(25);
        p = bclk0; found = 0;
        while (!found) begin
            @(negedge clk);
            found = !p && bclk0;
            p = bclk0;
        end
        clk_mode = 1'b0;
        hi0 = 0; b1hi = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (bclk0) hi0++;
            if (bclk1) b1hi++;
        end
        chk(b1hi == 0 && hi0 == 4, "R8", "mid-word pin change, bclk0 high count",
            hi0, 4);
        observe(60, 1'b0);
        chk(min0h >= 5 && min0l >= 5 && min1h >= 5 && min1l >= 5, "R8",
            "min run after switch to half", min0h, 5);
        clk_mode = 1'b1;
        observe(60, 1'b0);
        chk(min0h >= 5 && min0l >= 5 && min1h >= 5 && min1l >= 5, "R8",
            "min run after switch to full", min0l, 5);
    endtask

    // Realign in half-rate mode stretches without shortening any pulse.
    task automatic t_half_realign;
        int p;
        clk_mode = 1'b0;
        wait_cycles(30);
        realign_period(7, 1'b0, p);
        chk(p == 27, "R6", "half-rate period with shift 7", p, 27);
        fork
            observe(80, 1'b0);
            begin
                wait_cycles(15);
                realign_req = 1'b1; realign_shift = 4'd4;
                @(negedge clk); realign_req = 1'b0;
            end
        join
        chk(min0h >= 10 && min0l >= 10 && min1h >= 10 && min1l >= 10 && same == 0,
            "R8", "half-rate min run across realign", min0h, 10);
    endtask

    initial begin
        t_first_word();
        t_half();
        t_full();
        t_ddr();
        t_realign();
        t_boundary();
        t_half_realign();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule